// File: doc/BRIEF.md
# Flipped lifting 9/7 wavelet line engine

The block computes a one-dimensional forward 9/7 biorthogonal wavelet transform on a single line of `LINE_LEN` signed samples. Samples enter one per accepted cycle through a valid/ready handshake. Once a full line has been stored, the block runs the four lifting steps in place, one coefficient per cycle. It then streams the result as interleaved low-pass and high-pass coefficients. Each coefficient carries a band flag.

The lifting steps use the flipped arrangement. Every step divides through by the product of the earlier lifting constants. As a result each new value is one constant product of the node itself plus an unscaled sum of its two neighbours, and the multiplier never lies on the path of the neighbour sum. The final scaling constants put the results back into the usual normalisation. At both line ends, each step mirrors its neighbours about the end sample, without repeating that sample.

Two parameters set every internal node: integer bits `IB` and fraction bits `FB`. All adder operands therefore share one binary point. After each constant product the value is rounded to nearest or truncated, chosen by `ROUND_NEAR`, and wraps to the node width with no saturation. The output format is set by `OIB` and `OFB`.

Top module: `wav97_flip`

## Requirements
- R1: While reset is held and in the first cycle after it, `in_ready` is 1 and `out_valid` is 0.
- R2: The block accepts exactly `LINE_LEN` samples, one on each cycle where `in_valid` and `in_ready` are both 1. After the last sample, `in_ready` stays 0 until the last coefficient of the line has been taken. `in_ready` and `out_valid` are never 1 together.
- R3: A line yields exactly `LINE_LEN` coefficients. Coefficient i (counting from 0) has `out_high` = i mod 2, where 0 means low band and 1 means high band. The first is low, and each low is directly followed by a high.
- R4: With rounding to nearest, `out_data` is a two's-complement value with `OFB` fraction bits (default 2). Each coefficient is within 1 output ulp of a real-valued lifting model. That model uses alpha=-1.586134342, beta=-0.052980118, gamma=0.882911076, delta=0.443506852, low = 1.149604398 * s, and high = d / 1.149604398.
- R5: With truncation at every node (`ROUND_NEAR`=0), every coefficient is within 2 output ulp of the same model.
- R6: Each lifting step extends the line symmetrically about the first and last samples: neighbour -1 reads sample 1, and neighbour `LINE_LEN` reads sample `LINE_LEN`-2. The coefficients at both ends obey R4.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_high` hold their values into the next cycle and `out_valid` stays 1.
- R8: `in_valid` and `in_data` have no effect while `in_ready` is 0. Samples offered during computation or output never enter the next line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block is loading a line |
| in_data | input | XW | Signed input sample |
| out_valid | output | 1 | Coefficient available |
| out_ready | input | 1 | Consumer takes the coefficient |
| out_data | output | OIB+OFB | Signed fixed-point coefficient |
| out_high | output | 1 | 1 for high band, 0 for low band |

## Verification
The checker monitors the handshake on every cycle:
- the count of samples taken before output starts, and the count of coefficients given before loading resumes;
- that loading and output are exclusive;
- the low-then-high band order;
- that a stalled coefficient is held.

Numerical accuracy can only be shown by the bench's scenarios. These compare every coefficient against a real-valued lifting model for flat, extreme, alternating, ramp, end-impulse and random lines, in both the rounding and the truncating build. The ignored-input case is also shown only by the bench: junk is driven during computation, and the next line must still match its model.

// File: rtl/wav97_flip.sv
module wav97_flip #(
  parameter int LINE_LEN   = 16,
  parameter int XW         = 10,
  parameter int IB         = 18,
  parameter int FB         = 10,
  parameter int OIB        = 13,
  parameter int OFB        = 2,
  parameter int CF         = 16,
  parameter bit ROUND_NEAR = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic signed [XW-1:0]        in_data,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic signed [OIB+OFB-1:0]   out_data,
  output logic                        out_high
);
  localparam int W   = IB + FB;
  localparam int OW  = OIB + OFB;
  localparam int CW  = CF + 6;
  localparam int PW  = W + CW;
  localparam int IW  = $clog2(LINE_LEN);
  localparam int OSH = FB + CF - OFB;

  localparam real ALPHA = -1.586134342059924;
  localparam real BETA  = -0.052980118572961;
  localparam real GAMMA =  0.882911075530934;
  localparam real DELTA =  0.443506852043971;
  localparam real KAPPA =  1.149604398860241;
  localparam real SCL   = 2.0 ** CF;

  localparam logic signed [CW-1:0] K_S0 = CW'(longint'((1.0 / ALPHA) * SCL));
  localparam logic signed [CW-1:0] K_S1 = CW'(longint'((1.0 / (ALPHA * BETA)) * SCL));
  localparam logic signed [CW-1:0] K_S2 = CW'(longint'((1.0 / (BETA * GAMMA)) * SCL));
  localparam logic signed [CW-1:0] K_S3 = CW'(longint'((1.0 / (GAMMA * DELTA)) * SCL));
  localparam logic signed [CW-1:0] K_LO = CW'(longint'((KAPPA * ALPHA * BETA * GAMMA * DELTA) * SCL));
  localparam logic signed [CW-1:0] K_HI = CW'(longint'((ALPHA * BETA * GAMMA / KAPPA) * SCL));

  localparam logic signed [PW-1:0] HALF_L = ROUND_NEAR ? PW'(longint'(1) <<< (CF - 1))  : '0;
  localparam logic signed [PW-1:0] HALF_O = ROUND_NEAR ? PW'(longint'(1) <<< (OSH - 1)) : '0;

  localparam logic [IW-1:0] LAST   = IW'(LINE_LEN - 1);
  localparam logic [IW-1:0] LAST_E = IW'(LINE_LEN - 2);

  typedef enum logic [1:0] {ST_LOAD, ST_LIFT, ST_EMIT} st_t;

  st_t                 st;
  logic [IW-1:0]       idx;
  logic [1:0]          pass;
  logic signed [W-1:0] mem [LINE_LEN];

  logic                 odd_pass;
  logic [IW-1:0]        li, ri, last_pos;
  logic signed [CW-1:0] coef;
  logic signed [PW-1:0] prod;
  logic signed [W-1:0]  scaled, step_val;

  assign odd_pass = ~pass[0];
  assign last_pos = odd_pass ? LAST : LAST_E;
  assign li       = (idx == '0)   ? IW'(1) : idx - IW'(1);
  assign ri       = (idx == LAST) ? LAST_E : idx + IW'(1);

  always_comb begin
    if (st == ST_EMIT) coef = idx[0] ? K_HI : K_LO;
    else begin
      case (pass)
        2'd0:    coef = K_S0;
        2'd1:    coef = K_S1;
        2'd2:    coef = K_S2;
        default: coef = K_S3;
      endcase
    end
  end

  assign prod     = PW'(mem[idx]) * PW'(coef);
  assign scaled   = W'((prod + HALF_L) >>> CF);
  assign step_val = scaled + mem[li] + mem[ri];

  assign in_ready  = (st == ST_LOAD);
  assign out_valid = (st == ST_EMIT);
  assign out_high  = idx[0];
  assign out_data  = OW'((prod + HALF_O) >>> OSH);

  always_ff @(posedge clk) begin
    if (st == ST_LOAD && in_valid) mem[idx] <= W'(in_data) <<< FB;
    else if (st == ST_LIFT)        mem[idx] <= step_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_LOAD;
      idx  <= '0;
      pass <= '0;
    end else begin
      case (st)
        ST_LOAD: if (in_valid) begin
          if (idx == LAST) begin
            st   <= ST_LIFT;
            idx  <= IW'(1);
            pass <= '0;
          end else idx <= idx + IW'(1);
        end
        ST_LIFT: begin
          if (idx == last_pos) begin
            if (pass == 2'd3) begin
              st  <= ST_EMIT;
              idx <= '0;
            end else begin
              pass <= pass + 2'd1;
              idx  <= IW'(pass[0]);
            end
          end else idx <= idx + IW'(2);
        end
        default: if (out_ready) begin
          if (idx == LAST) st <= ST_LOAD;
          idx <= (idx == LAST) ? '0 : idx + IW'(1);
        end
      endcase
    end
  end
endmodule

// File: rtl/wav97_flip_chk.sv
module wav97_flip_chk #(
  parameter int LINE_LEN = 16,
  parameter int OW       = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [OW-1:0] out_data,
  input logic          out_high
);
  logic [31:0] in_cnt, out_cnt;
  wire in_fire  = in_valid & in_ready;
  wire out_fire = out_valid & out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cnt  <= '0;
      out_cnt <= '0;
    end else begin
      in_cnt  <= out_fire ? 32'd0 : in_cnt + {31'd0, in_fire};
      out_cnt <= in_fire  ? 32'd0 : out_cnt + {31'd0, out_fire};
    end
  end

  AST_LOAD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> in_cnt == 32'(LINE_LEN)); // R2
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid)); // R2
  AST_EMIT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> out_cnt == 32'(LINE_LEN)); // R3
  AST_FIRST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> !out_high); // R3
  AST_HIGH_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_high |=> out_valid && out_high); // R3
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_high)); // R7
endmodule

bind wav97_flip wav97_flip_chk #(.LINE_LEN(LINE_LEN), .OW(OIB + OFB)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_high(out_high)
);

// File: tb/wav97_flip_test.sv
`timescale 1ns/1ps
module wav97_flip_test;
  localparam int N   = 16;
  localparam int XW  = 10;
  localparam int OFB = 2;
  localparam int OW  = 13 + OFB;
  localparam real ULP   = 1.0 / (2.0 ** OFB);
  localparam real ALPHA = -1.586134342059924;
  localparam real BETA  = -0.052980118572961;
  localparam real GAMMA =  0.882911075530934;
  localparam real DELTA =  0.443506852043971;
  localparam real KAPPA =  1.149604398860241;

  logic clk = 0, rst_n = 0, in_valid = 0, out_ready = 0;
  logic signed [XW-1:0] in_data = '0;
  logic in_ready, out_valid, out_high, t_in_ready, t_out_valid, t_out_high;
  logic signed [OW-1:0] out_data, t_out_data;

  int tests = 0, fails = 0;
  int xs [N];
  real exp_lo [N/2], exp_hi [N/2];

  always #10 clk = ~clk;

  wav97_flip #(.LINE_LEN(N), .ROUND_NEAR(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_high(out_high));

  wav97_flip #(.LINE_LEN(N), .ROUND_NEAR(1'b0)) uut_trunc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(t_in_ready), .in_data(in_data),
    .out_valid(t_out_valid), .out_ready(out_ready), .out_data(t_out_data), .out_high(t_out_high));

  task automatic chk(input bit ok, input string msg);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic int mir(input int j);
    if (j < 0) return -j;
    if (j > N - 1) return 2 * N - 2 - j;
    return j;
  endfunction

  function automatic void build_model();
    real v [N];
    for (int k = 0; k < N; k++) v[k] = xs[k];
    for (int k = 1; k < N; k += 2) v[k] += ALPHA * (v[mir(k-1)] + v[mir(k+1)]);
    for (int k = 0; k < N; k += 2) v[k] += BETA  * (v[mir(k-1)] + v[mir(k+1)]);
    for (int k = 1; k < N; k += 2) v[k] += GAMMA * (v[mir(k-1)] + v[mir(k+1)]);
    for (int k = 0; k < N; k += 2) v[k] += DELTA * (v[mir(k-1)] + v[mir(k+1)]);
    for (int k = 0; k < N / 2; k++) begin
      exp_lo[k] = KAPPA * v[2*k];
      exp_hi[k] = v[2*k+1] / KAPPA;
    end
  endfunction

  function automatic real absr(input real a);
    return (a < 0.0) ? -a : a;
  endfunction

  task automatic send_line();
    int i = 0;
    @(negedge clk);
    chk(in_ready == 1'b1, $sformatf("R2 load start: in_ready actual %0b expected 1", in_ready));
    while (i < N) begin
      if (i > 0) @(negedge clk);
      if ($urandom % 3 == 0) in_valid = 1'b0;
      else begin
        in_valid = 1'b1;
        in_data  = XW'(xs[i]);
        if (in_ready) i++;
      end
    end
  endtask

  task automatic collect(input bit junk);
    int got = 0, cyc = 0;
    bit held = 0, hh = 0;
    logic signed [OW-1:0] hd = '0;
    while (got < N && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (held) chk(out_valid && out_data == hd && out_high == hh,
        $sformatf("R7 stall hold: actual %0d/%0b expected %0d/%0b", out_data, out_high, hd, hh));
      held = 0;
      in_valid = junk;
      in_data  = XW'($urandom);
      if (out_valid) begin
        if (got == 0) chk(in_ready == 1'b0, $sformatf("R2 busy: in_ready actual %0b expected 0", in_ready));
        out_ready = ($urandom % 4) != 0;
        if (out_ready) begin
          real e = out_high ? exp_hi[got/2] : exp_lo[got/2];
          real a = $itor(out_data) * ULP;
          real ta = $itor(t_out_data) * ULP;
          string rq = (got == 0 || got == N - 1) ? "R6" : "R4";
          chk(out_high == got[0], $sformatf("R3 band at %0d: actual %0b expected %0b", got, out_high, got[0]));
          chk(absr(a - e) <= ULP, $sformatf("%s coef %0d: actual %f expected %f", rq, got, a, e));
          chk(t_out_valid && absr(ta - e) <= 2.0 * ULP,
              $sformatf("R5 coef %0d: actual %f expected %f", got, ta, e));
          got++;
        end else begin
          held = 1; hd = out_data; hh = out_high;
        end
      end else out_ready = $urandom % 2;
    end
    chk(got == N, $sformatf("R3 count: actual %0d expected %0d", got, N));
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b0;
    chk(in_ready == 1'b1 && out_valid == 1'b0,
        $sformatf("R2 line end: in_ready/out_valid actual %0b/%0b expected 1/0", in_ready, out_valid));
  endtask

  task automatic run_line(input int kind, input bit junk);
    for (int k = 0; k < N; k++) begin
      case (kind)
        0: xs[k] = 0;
        1: xs[k] = 511;
        2: xs[k] = -512;
        3: xs[k] = (k % 2 == 0) ? 511 : -512;
        4: xs[k] = (k == 0) ? 300 : 0;
        5: xs[k] = (k == N - 1) ? -400 : 0;
        6: xs[k] = k * 60 - 480;
        default: xs[k] = int'($urandom_range(1023, 0)) - 512;
      endcase
    end
    build_model();
    send_line();
    collect(junk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0,
        $sformatf("R1 in reset: in_ready/out_valid actual %0b/%0b expected 1/0", in_ready, out_valid));
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0,
        $sformatf("R1 after reset: in_ready/out_valid actual %0b/%0b expected 1/0", in_ready, out_valid));
    for (int kind = 0; kind < 7; kind++) run_line(kind, 1'b0);
    for (int n = 0; n < 8; n++) run_line(7, 1'b1); // R8: junk offered while busy
    run_line(4, 1'b1);                              // R8 then R6 edge impulse
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule